// File: doc/BRIEF.md
# Programmable Receive Sync Hunter

This block watches a sampled serial receive stream and finds frame alignment. Each received bit arrives with a one-cycle valid strobe. While hunting, the block compares the most recent bits against a programmable sync word. The compare window is 4, 8 or 16 bits wide, as chosen by a 2-bit mode field. A fourth mode skips the pattern search and takes a rising carrier-detect input as the sync event. When a match is found, a one-cycle sync pulse is raised and an in-sync level is set. The bit that carries the first data of the frame is then marked with its own one-cycle pulse.

Once aligned, the block stops searching. It stays locked until a resync request, a configuration change or a disable sends it back to an empty hunt. A delayed-alignment control bit applies only to carrier-detect mode. It moves the first-data marker one bit later.

Top module: `sync_hunter`

## Requirements
- R1: A synchronous active-high `rst` clears the history and the fill count, drives `sync_pulse`, `in_sync` and `first_bit` low, and returns the block to the hunt state.
- R2: With `mode` = 2'b01, the block hunts for `sync_pattern[3:0]`, and bits [15:4] have no effect. On a match, `sync_pulse` is high for exactly the one cycle after the strobe that carried the final pattern bit, and `in_sync` rises in that same cycle.
- R3: With `mode` = 2'b10, the block hunts for `sync_pattern[7:0]`, with the same output timing as R2.
- R4: With `mode` = 2'b11, the block hunts for all 16 bits of `sync_pattern`, with the same output timing as R2.
- R5: Each cycle with `bit_valid` high shifts one bit into the history. Cycles with `bit_valid` low have no effect. Pattern bit 0 is compared with the newest bit, and pattern bit L-1 with the oldest of the last L bits, so the sync word is sent most significant bit first.
- R6: No match is declared until at least L bits have been accepted since the hunt last restarted, even when the empty history already equals the pattern.
- R7: `first_bit` is a one-cycle pulse in the cycle after the strobe of the bit that follows the final pattern bit, and it occurs once per lock.
- R8: With `mode` = 2'b00 and `late_align` = 0, an accepted bit is the sync event when `carrier_det` is 1 on it and was 0 on the previous accepted bit since the hunt restarted. The carrier-detect history is taken as 0 right after a restart. In the next cycle `sync_pulse`, `in_sync` and `first_bit` are all high, because that bit is the first data bit.
- R9: With `mode` = 2'b00 and `late_align` = 1, the sync event raises `sync_pulse` and `in_sync` as in R8, but `first_bit` waits for the next accepted bit.
- R10: While in sync, incoming bits and carrier-detect changes raise no further `sync_pulse`, and `in_sync` stays high.
- R11: A cycle with `resync` high and `enable` high clears `in_sync` in the next cycle and empties the history. A bit strobed in that cycle is discarded.
- R12: A change of `mode` or `sync_pattern` while `enable` is high has the same effect as R11 in the cycle it is first seen.
- R13: While `enable` is low, `in_sync` is low from the next cycle, no sync is declared, and the history stays empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; low holds the block cleared |
| mode | input | 2 | 00 carrier detect, 01 4-bit, 10 8-bit, 11 16-bit pattern |
| sync_pattern | input | PAT_W (16) | Sync word, low-order bits used for short modes |
| late_align | input | 1 | Carrier detect marks the second bit instead of the first |
| resync | input | 1 | Return to hunt with empty history |
| bit_valid | input | 1 | Strobe: `bit_in` holds a new received bit |
| bit_in | input | 1 | Received serial bit |
| carrier_det | input | 1 | External carrier-detect level, sampled with each bit |
| sync_pulse | output | 1 | One-cycle pulse when sync is found |
| in_sync | output | 1 | Level, high while aligned |
| first_bit | output | 1 | One-cycle pulse marking the first data bit |

## Verification
The pattern modes are driven with a preamble that leaves a near miss in the window just before the real sync word. This separates correct bit ordering from a reversed compare. Sync words of all zeros are sent right after a restart, so a block that matches on the empty history before it has filled is caught. Strobes with idle gaps between them show that only valid cycles shift the history. The carrier-detect mode is run with both alignment settings, and with carrier detect already high when a hunt restarts, which shows that the edge is found against a cleared history. A long random mix of bits, strobes, resyncs, disables and configuration changes is compared cycle by cycle with a bench model, to cover the orderings the directed cases miss.

// File: rtl/sh_pkg.sv
package sh_pkg;

  typedef enum logic [1:0] {
    SH_EXT  = 2'b00,
    SH_NIB  = 2'b01,
    SH_BYTE = 2'b10,
    SH_WORD = 2'b11
  } sh_mode_e;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_WAIT = 2'd1,
    ST_LOCK = 2'd2
  } sh_state_e;

  // Number of compared bits for a mode, given the full pattern width.
  function automatic int unsigned sh_len(sh_mode_e m, int unsigned w);
    case (m)
      SH_NIB:  return w / 4;
      SH_BYTE: return w / 2;
      SH_WORD: return w;
      default: return 0;
    endcase
  endfunction

  // Saturating increment of the fill count.
  function automatic int unsigned sh_fill_inc(int unsigned f, int unsigned w);
    return (f >= w) ? w : f + 1;
  endfunction

endpackage

// File: rtl/sh_history.sv
module sh_history #(
  parameter int unsigned W  = 16,
  parameter int unsigned CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          shift,
  input  logic          bit_in,
  output logic [W-1:0]  hist_nxt,
  output logic [CW-1:0] fill_nxt
);
  import sh_pkg::*;

  logic [W-1:0]  hist_q;
  logic [CW-1:0] fill_q;

  always_comb begin
    hist_nxt = hist_q;
    fill_nxt = fill_q;
    if (shift) begin
      hist_nxt = {hist_q[W-2:0], bit_in};
      fill_nxt = CW'(sh_fill_inc(int'(fill_q), W));
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      hist_q <= '0;
      fill_q <= '0;
    end else begin
      hist_q <= hist_nxt;
      fill_q <= fill_nxt;
    end
  end

endmodule

// File: rtl/sh_matcher.sv
module sh_matcher #(
  parameter int unsigned W  = 16,
  parameter int unsigned CW = $clog2(W + 1)
) (
  input  logic [1:0]    mode,
  input  logic [W-1:0]  pattern,
  input  logic [W-1:0]  hist,
  input  logic [CW-1:0] fill,
  output logic          hit
);
  import sh_pkg::*;

  logic [CW-1:0] len;
  logic [W-1:0]  mask;
  logic [W-1:0]  diff;

  assign len = CW'(sh_len(sh_mode_e'(mode), W));

  for (genvar i = 0; i < W; i++) begin : g_mask
    assign mask[i] = (CW'(i) < len);
  end

  assign diff = (hist ^ pattern) & mask;
  assign hit  = (sh_mode_e'(mode) != SH_EXT) && (fill >= len) && (diff == '0);

endmodule

// File: rtl/sh_ctrl.sv
module sh_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic accept,
  input  logic ext_mode,
  input  logic late_align,
  input  logic carrier_det,
  input  logic hit,
  output logic sync_pulse,
  output logic in_sync,
  output logic first_bit,
  output logic hunting
);
  import sh_pkg::*;

  sh_state_e state_q;
  logic      cd_prev_q;
  logic      cd_edge;

  assign hunting = (state_q == ST_HUNT);
  assign in_sync = !hunting;
  assign cd_edge = carrier_det && !cd_prev_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      state_q    <= ST_HUNT;
      sync_pulse <= 1'b0;
      first_bit  <= 1'b0;
      cd_prev_q  <= 1'b0;
    end else begin
      sync_pulse <= 1'b0;
      first_bit  <= 1'b0;
      if (accept) begin
        case (state_q)
          ST_HUNT: begin
            if (ext_mode) begin
              cd_prev_q <= carrier_det;
              if (cd_edge) begin
                sync_pulse <= 1'b1;
                if (late_align) begin
                  state_q <= ST_WAIT;
                end else begin
                  first_bit <= 1'b1;
                  state_q   <= ST_LOCK;
                end
              end
            end else if (hit) begin
              sync_pulse <= 1'b1;
              state_q    <= ST_WAIT;
            end
          end
          ST_WAIT: begin
            first_bit <= 1'b1;
            state_q   <= ST_LOCK;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/sync_hunter.sv
module sync_hunter #(
  parameter int unsigned PAT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [1:0]       mode,
  input  logic [PAT_W-1:0] sync_pattern,
  input  logic             late_align,
  input  logic             resync,
  input  logic             bit_valid,
  input  logic             bit_in,
  input  logic             carrier_det,
  output logic             sync_pulse,
  output logic             in_sync,
  output logic             first_bit
);
  import sh_pkg::*;

  localparam int unsigned CW    = $clog2(PAT_W + 1);
  localparam int unsigned CFG_W = PAT_W + 2;

  logic [CFG_W-1:0] cfg_now;
  logic [CFG_W-1:0] cfg_q;
  logic             cfg_changed;
  logic             hist_clear;
  logic             accept;
  logic             hunting;
  logic             shift;
  logic             pattern_hit;
  logic             ext_mode;
  logic [PAT_W-1:0] hist_nxt;
  logic [CW-1:0]    fill_nxt;

  assign cfg_now = {mode, sync_pattern};

  always_ff @(posedge clk) begin
    cfg_q <= cfg_now;
  end

  assign cfg_changed = enable && (cfg_now != cfg_q);
  assign hist_clear  = !enable || cfg_changed || resync;
  assign accept      = bit_valid && !hist_clear;
  assign shift       = accept && hunting;
  assign ext_mode    = (sh_mode_e'(mode) == SH_EXT);

  sh_history #(.W(PAT_W), .CW(CW)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .clear    (hist_clear),
    .shift    (shift),
    .bit_in   (bit_in),
    .hist_nxt (hist_nxt),
    .fill_nxt (fill_nxt)
  );

  sh_matcher #(.W(PAT_W), .CW(CW)) u_match (
    .mode    (mode),
    .pattern (sync_pattern),
    .hist    (hist_nxt),
    .fill    (fill_nxt),
    .hit     (pattern_hit)
  );

  sh_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .clear       (hist_clear),
    .accept      (accept),
    .ext_mode    (ext_mode),
    .late_align  (late_align),
    .carrier_det (carrier_det),
    .hit         (pattern_hit),
    .sync_pulse  (sync_pulse),
    .in_sync     (in_sync),
    .first_bit   (first_bit),
    .hunting     (hunting)
  );

endmodule

// File: rtl/sh_checker.sv
module sh_checker (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic resync,
  input logic bit_valid,
  input logic cfg_changed,
  input logic hist_clear,
  input logic sync_pulse,
  input logic in_sync,
  input logic first_bit
);

  AST_PULSE_SETS_LOCK: assert property (@(posedge clk) disable iff (rst)
    sync_pulse |-> in_sync); // R2

  AST_PULSE_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    sync_pulse |-> $past(bit_valid)); // R5

  AST_FIRST_IN_LOCK: assert property (@(posedge clk) disable iff (rst)
    first_bit |-> in_sync); // R7

  AST_FIRST_SINGLE: assert property (@(posedge clk) disable iff (rst)
    first_bit |=> !first_bit); // R7

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sync_pulse |=> !sync_pulse); // R10

  AST_LOCK_KEEP: assert property (@(posedge clk) disable iff (rst)
    (in_sync && !hist_clear) |=> in_sync); // R10

  AST_RESYNC_DROP: assert property (@(posedge clk) disable iff (rst)
    (enable && resync) |=> (!in_sync && !sync_pulse)); // R11

  AST_CFG_DROP: assert property (@(posedge clk) disable iff (rst)
    cfg_changed |=> (!in_sync && !sync_pulse)); // R12

  AST_DISABLE_DROP: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!in_sync && !first_bit && !sync_pulse)); // R13

endmodule

bind sync_hunter sh_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .enable      (enable),
  .resync      (resync),
  .bit_valid   (bit_valid),
  .cfg_changed (cfg_changed),
  .hist_clear  (hist_clear),
  .sync_pulse  (sync_pulse),
  .in_sync     (in_sync),
  .first_bit   (first_bit)
);

// File: tb/sync_hunter_bench.sv
module sync_hunter_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [1:0]  mode = 2'b01;
  logic [15:0] sync_pattern = 16'h0000;
  logic        late_align = 1'b0;
  logic        resync = 1'b0;
  logic        bit_valid = 1'b0;
  logic        bit_in = 1'b0;
  logic        carrier_det = 1'b0;
  logic        sync_pulse, in_sync, first_bit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sync_hunter u_sync_hunter (
    .clk(clk), .rst(rst), .enable(enable), .mode(mode),
    .sync_pattern(sync_pattern), .late_align(late_align), .resync(resync),
    .bit_valid(bit_valid), .bit_in(bit_in), .carrier_det(carrier_det),
    .sync_pulse(sync_pulse), .in_sync(in_sync), .first_bit(first_bit)
  );

  // Bench model state
  logic [15:0] m_hist = '0;
  int          m_fill = 0;
  int          m_state = 0;   // 0 hunt, 1 wait first bit, 2 locked
  bit          m_cdp = 1'b0;
  logic [17:0] m_cfg = '0;
  bit          e_sp = 1'b0, e_fb = 1'b0;

  function automatic int b_len(logic [1:0] m);
    return (m == 2'b01) ? 4 : (m == 2'b10) ? 8 : (m == 2'b11) ? 16 : 0;
  endfunction

  function automatic bit b_match(logic [15:0] h, logic [15:0] p, logic [1:0] m);
    int L = b_len(m);
    for (int k = 0; k < L; k++) if (h[k] != p[k]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic m_clear();
    m_hist = '0; m_fill = 0; m_state = 0; m_cdp = 1'b0;
  endtask

  task automatic model_step();
    e_sp = 1'b0; e_fb = 1'b0;
    if (rst) m_clear();
    else if (!enable) m_clear();
    else if ({mode, sync_pattern} != m_cfg) m_clear();
    else if (resync) m_clear();
    else if (bit_valid) begin
      if (m_state == 0) begin
        if (mode == 2'b00) begin
          if (carrier_det && !m_cdp) begin
            e_sp = 1'b1;
            if (late_align) m_state = 1;
            else begin e_fb = 1'b1; m_state = 2; end
          end
          m_cdp = carrier_det;
        end else begin
          m_hist = {m_hist[14:0], bit_in};
          m_fill = (m_fill >= 16) ? 16 : m_fill + 1;
          if (m_fill >= b_len(mode) && b_match(m_hist, sync_pattern, mode)) begin
            e_sp = 1'b1; m_state = 1;
          end
        end
      end else if (m_state == 1) begin
        e_fb = 1'b1; m_state = 2;
      end
    end
    m_cfg = {mode, sync_pattern};
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string sp_tag();
    case (mode)
      2'b00: return late_align ? "R9" : "R8";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  // One clock: inputs already set, model advances, compare after the edge.
  task automatic cyc();
    string t;
    model_step();
    t = sp_tag();
    @(posedge clk); #1;
    check(sync_pulse == e_sp, t, sync_pulse, e_sp);
    check(in_sync == (m_state != 0), "R10", in_sync, m_state != 0);
    check(first_bit == e_fb, "R7", first_bit, e_fb);
  endtask

  task automatic send(bit b);
    bit_valid = 1'b1; bit_in = b; cyc(); bit_valid = 1'b0;
  endtask

  task automatic idle(int n);
    bit_valid = 1'b0;
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic send_word(logic [15:0] w, int L);
    for (int k = L - 1; k >= 0; k--) send(w[k]);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int pulses;
    #1;
    // R1 reset
    rst = 1'b1; enable = 1'b1; mode = 2'b01; sync_pattern = 16'hF0A6;
    idle(3);
    check(!in_sync && !sync_pulse && !first_bit, "R1", in_sync, 0);
    rst = 1'b0;
    idle(2);

    // R2/R5: nibble 0110 after preamble 1,1 (near miss 1101 first)
    send(1); send(1); send(0); send(1); send(1);
    check(!in_sync, "R5", in_sync, 0);
    send(0);
    check(sync_pulse == 1'b1, "R2", sync_pulse, 1);
    check(in_sync == 1'b1, "R2", in_sync, 1);
    send(1);
    check(first_bit == 1'b1, "R7", first_bit, 1);

    // R10: pattern again while locked
    pulses = 0;
    for (int i = 0; i < 8; i++) begin send(i[0] ^ i[1]); pulses += sync_pulse; end
    check(pulses == 0 && in_sync, "R10", pulses, 0);

    // R12: pattern change while locked
    sync_pattern = 16'hF0A7; idle(1);
    check(!in_sync, "R12", in_sync, 0);

    // R4/R6: 16-bit all-zero word needs a full window
    mode = 2'b11; sync_pattern = 16'h0000; idle(1);
    for (int i = 0; i < 15; i++) send(0);
    check(!in_sync, "R6", in_sync, 0);
    send(0);
    check(sync_pulse == 1'b1, "R4", sync_pulse, 1);

    // R11: resync with a strobed bit that must be discarded
    resync = 1'b1; send(0); resync = 1'b0;
    check(!in_sync, "R11", in_sync, 0);
    for (int i = 0; i < 15; i++) send(0);
    check(!in_sync, "R11", in_sync, 0);
    send(0);
    check(sync_pulse == 1'b1, "R11", sync_pulse, 1);

    // R3/R5: byte 0x96 with idle gaps and a near-miss preamble
    mode = 2'b10; sync_pattern = 16'h3C96; idle(1);
    send_word(16'h0096 >> 1, 8);
    for (int k = 7; k >= 0; k--) begin send(sync_pattern[k]); idle(k % 3); end
    check(in_sync == 1'b1, "R3", in_sync, 1);
    check(in_sync == 1'b1, "R5", in_sync, 1);

    // R8: carrier detect, first bit on the edge bit
    mode = 2'b00; late_align = 1'b0; carrier_det = 1'b0; idle(1);
    send(0); send(1); carrier_det = 1'b1; send(1);
    check(sync_pulse && first_bit, "R8", first_bit, 1);

    // R9: late alignment, carrier already high at restart
    late_align = 1'b1; resync = 1'b1; idle(1); resync = 1'b0;
    send(0);
    check(sync_pulse && !first_bit, "R9", first_bit, 0);
    send(1);
    check(first_bit == 1'b1, "R9", first_bit, 1);

    // R13: disable, with strobes and carrier edges while off
    enable = 1'b0;
    carrier_det = 1'b0; send(1); carrier_det = 1'b1; send(1);
    check(!in_sync && !sync_pulse, "R13", in_sync, 0);
    enable = 1'b1; idle(1);

    // Random phase
    void'($urandom(32'd1357));
    for (int n = 0; n < 6000; n++) begin
      bit_valid = ($urandom % 4) != 0;
      bit_in    = $urandom % 2;
      if ($urandom % 16 == 0) carrier_det = ~carrier_det;
      resync    = ($urandom % 200) == 0;
      if ($urandom % 300 == 0) enable = ~enable;
      if ($urandom % 400 == 0) mode = 2'($urandom);
      if ($urandom % 500 == 0) sync_pattern = 16'($urandom % 8);
      if ($urandom % 250 == 0) late_align = ~late_align;
      cyc();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule